// File: doc/BRIEF.md
# Sequence-Keyed Reconfiguration Gate with Attempt Lockout

This block guards the enable of a downstream mode reconfigurator. A secret initialization key is built into the design as a parameter. The key is presented serially as 4-bit symbols. The first symbol is the most significant nibble of the key and the last is the least significant. A separate strobe marks the end of each attempt. When the whole symbol sequence matches and the attempt ends, the reconfigurator enable rises. It then stays high until reset. Configuration data only passes to the reconfigurator while that enable is high. At all other times it is held off.

Every rejected key attempt counts as one failure. While the block is unlocked, every alarm-mode configuration reported back by the reconfigurator also counts as one failure. Both kinds go into one shared counter. When the count passes a fixed threshold, the block enters a denial-of-use state. In that state the enable drops and all later key attempts are refused. Only the asynchronous power-on reset leaves this state.

Top module: `seqKeyGate`

## Requirements
- R1: After reset, `reconfigEnable`, `lockout` and `cfgLoad` are 0 and `cfgWord` is 0.
- R2: An attempt that unlocks has three parts. It supplies exactly KEY_BITS/4 symbols, the most significant nibble of KEY_VALUE first, and then `attemptDone` is pulsed. After such an attempt, `reconfigEnable` is 1 from the cycle after the edge that samples `attemptDone`, and it stays 1 until reset or lockout.
- R3: An attempt with any mismatching symbol, in any position, leaves `reconfigEnable` at 0. It counts as one failure, and the sequence restarts from the first symbol. A correct attempt made afterwards still unlocks.
- R4: An attempt that has too few symbols or too many symbols is rejected. It counts as one failure.
- R5: While `reconfigEnable` is 0, `cfgLoad` is 0 and `cfgWord` is 0, whatever `cfgValid` and `cfgData` are. While it is 1, `cfgLoad` follows `cfgValid` and `cfgWord` equals `cfgData`.
- R6: Each cycle in which `alarmSeen` is 1 while the block is unlocked counts as one failure.
- R7: Lockout happens on the failure that makes the count exceed THRESH, which is failure number THRESH+1. `lockout` becomes 1 in the cycle after the edge that records that failure, and `reconfigEnable` becomes 0 in the same cycle. Afterwards even the correct key does not unlock.
- R8: `lockout` stays 1 until the asynchronous reset is asserted.
- R9: A successful unlock does not clear the failure count. Failures recorded before the unlock and alarms recorded after it add up toward the threshold.
- R10: While the block is unlocked, symbols and `attemptDone` have no effect. `reconfigEnable` stays 1 and no failure is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| symValid | input | 1 | Key symbol strobe |
| symData | input | 4 | Key symbol |
| attemptDone | input | 1 | End of a key attempt |
| alarmSeen | input | 1 | Reconfigurator reports an alarm-mode configuration |
| cfgValid | input | 1 | Configuration data strobe |
| cfgData | input | CFG_BITS | Configuration data |
| reconfigEnable | output | 1 | Reconfigurator may accept configuration |
| lockout | output | 1 | Denial-of-use state |
| cfgLoad | output | 1 | Gated configuration strobe |
| cfgWord | output | CFG_BITS | Gated configuration data |

## Verification
The bench places a wrong symbol in the first position and in the last position. A design that checked only part of the sequence, or that compared the nibbles in reverse order, would unlock on one of these. It sends attempts that are one symbol short and one symbol long, to catch a design that unlocks on a prefix or that ignores extra symbols. It counts failures up to exactly THRESH and then THRESH+1 with wrong keys, with alarms, and with a mix of the two across an unlock. This exposes an off-by-one threshold, a counter that unlocking resets, and alarms counted into a different total. It also checks that key traffic while unlocked, and the correct key after lockout, change nothing.

// File: rtl/seqKeyPkg.sv
package seqKeyPkg;
  localparam int SYM_BITS = 4;

  typedef struct packed {
    logic symProbe;  // a key symbol is being compared this cycle
    logic failInc;   // record one failure
  } ctrlStrobe_t;
endpackage

// File: rtl/seqKeyPath.sv
module seqKeyPath
  import seqKeyPkg::*;
#(
  parameter int KEY_BITS = 32,
  parameter logic [KEY_BITS-1:0] KEY_VALUE = 32'h9E3A_5C71,
  parameter int THRESH = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [$clog2(KEY_BITS/SYM_BITS+1)-1:0] pos,
  input  logic [SYM_BITS-1:0] symData,
  output logic                symMatch,
  output logic                locked
);
  localparam int NSYM = KEY_BITS / SYM_BITS;
  localparam int POSW = $clog2(NSYM + 1);
  localparam int IDXW = $clog2(NSYM);
  localparam int CW   = $clog2(THRESH + 2);

  logic [SYM_BITS-1:0] keyNib [NSYM];
  logic [CW-1:0] failCnt, cntNext;

  // symbol 0 is the most significant nibble
  for (genvar g = 0; g < NSYM; g++) begin : gNib
    assign keyNib[g] = KEY_VALUE[KEY_BITS-1-SYM_BITS*g -: SYM_BITS];
  end

  assign symMatch = strb.symProbe && (pos < POSW'(NSYM)) &&
                    (keyNib[pos[IDXW-1:0]] == symData);

  assign cntNext = (strb.failInc && failCnt != CW'(THRESH + 1)) ?
                   failCnt + CW'(1) : failCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failCnt <= '0;
      locked  <= 1'b0;
    end else begin
      failCnt <= cntNext;
      locked  <= locked | (cntNext > CW'(THRESH));
    end
  end

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    failCnt <= CW'(THRESH + 1));
  assert_lock_on_excess_R7: assert property (@(posedge clk) disable iff (!rstN)
    (failCnt > CW'(THRESH)) |-> locked);
  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(locked) |-> locked);
endmodule

// File: rtl/seqKeyCtrl.sv
module seqKeyCtrl
  import seqKeyPkg::*;
#(
  parameter int KEY_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        symValid,
  input  logic        attemptDone,
  input  logic        alarmSeen,
  input  logic        symMatch,
  input  logic        locked,
  output ctrlStrobe_t strb,
  output logic [$clog2(KEY_BITS/SYM_BITS+1)-1:0] pos,
  output logic        isOpen
);
  localparam int NSYM = KEY_BITS / SYM_BITS;
  localparam int POSW = $clog2(NSYM + 1);

  typedef enum logic {mSeek, mOpen} mode_t;
  mode_t mode;
  logic  bad, badNext, accept, posFull, endNow, goodEnd;
  logic [POSW-1:0] posNext;

  assign accept  = !locked && mode == mSeek;
  assign posFull = pos == POSW'(NSYM);
  assign endNow  = accept && attemptDone;

  always_comb begin
    posNext = pos;
    badNext = bad;
    if (accept && symValid) begin
      if (posFull) badNext = 1'b1;   // too many symbols
      else begin
        if (!symMatch) badNext = 1'b1;
        posNext = pos + POSW'(1);
      end
    end
  end

  assign goodEnd       = endNow && !badNext && posNext == POSW'(NSYM);
  assign strb.symProbe = accept && symValid;
  assign strb.failInc  = (endNow && !goodEnd) ||
                         (mode == mOpen && !locked && alarmSeen);
  assign isOpen        = mode == mOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode <= mSeek;
      pos  <= '0;
      bad  <= 1'b0;
    end else if (endNow) begin
      pos  <= '0;
      bad  <= 1'b0;
      if (goodEnd) mode <= mOpen;
    end else begin
      pos <= posNext;
      bad <= badNext;
    end
  end

  assert_open_needs_end_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mode == mOpen) |-> $past(attemptDone));
  assert_open_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(mode == mOpen) |-> mode == mOpen);
  assert_pos_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    pos <= POSW'(NSYM));
endmodule

// File: rtl/seqKeyGate.sv
module seqKeyGate
  import seqKeyPkg::*;
#(
  parameter int KEY_BITS = 32,
  parameter logic [KEY_BITS-1:0] KEY_VALUE = 32'h9E3A_5C71,
  parameter int THRESH = 7,
  parameter int CFG_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                symValid,
  input  logic [SYM_BITS-1:0] symData,
  input  logic                attemptDone,
  input  logic                alarmSeen,
  input  logic                cfgValid,
  input  logic [CFG_BITS-1:0] cfgData,
  output logic                reconfigEnable,
  output logic                lockout,
  output logic                cfgLoad,
  output logic [CFG_BITS-1:0] cfgWord
);
  localparam int POSW = $clog2(KEY_BITS / SYM_BITS + 1);

  ctrlStrobe_t     strb;
  logic [POSW-1:0] pos;
  logic            symMatch, locked, isOpen;

  seqKeyCtrl #(.KEY_BITS(KEY_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .symValid(symValid), .attemptDone(attemptDone),
    .alarmSeen(alarmSeen), .symMatch(symMatch), .locked(locked),
    .strb(strb), .pos(pos), .isOpen(isOpen)
  );

  seqKeyPath #(.KEY_BITS(KEY_BITS), .KEY_VALUE(KEY_VALUE), .THRESH(THRESH)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .pos(pos), .symData(symData),
    .symMatch(symMatch), .locked(locked)
  );

  assign lockout        = locked;
  assign reconfigEnable = isOpen && !locked;
  assign cfgLoad        = reconfigEnable && cfgValid;
  assign cfgWord        = reconfigEnable ? cfgData : '0;

  assert_lock_kills_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    lockout |-> !reconfigEnable);
  assert_cfg_blocked_R5: assert property (@(posedge clk) disable iff (!rstN)
    !reconfigEnable |-> (!cfgLoad && cfgWord == '0));
endmodule

// File: tb/tb_seqKeyGate.sv
module tb_seqKeyGate;
  localparam int KEY_BITS = 32;
  localparam logic [KEY_BITS-1:0] KEY = 32'h9E3A_5C71;
  localparam int THRESH = 7;
  localparam int CFG_BITS = 8;
  localparam int NSYM = KEY_BITS / 4;

  logic clk = 0, rstN = 0;
  logic symValid = 0, attemptDone = 0, alarmSeen = 0, cfgValid = 0;
  logic [3:0] symData = 0;
  logic [CFG_BITS-1:0] cfgData = 0;
  logic reconfigEnable, lockout, cfgLoad;
  logic [CFG_BITS-1:0] cfgWord;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  seqKeyGate #(.KEY_BITS(KEY_BITS), .KEY_VALUE(KEY), .THRESH(THRESH),
               .CFG_BITS(CFG_BITS)) dut (.*);

  function automatic logic [3:0] nib(int i);
    return KEY[KEY_BITS-1-4*i -: 4];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    @(negedge clk); @(negedge clk); rstN = 1;
    @(negedge clk);
  endtask

  task automatic sendSym(logic [3:0] d);
    symValid = 1; symData = d; @(negedge clk); symValid = 0;
  endtask

  task automatic endAttempt();
    attemptDone = 1; @(negedge clk); attemptDone = 0;
  endtask

  // n symbols of the key; position wrongAt gets a flipped nibble (-1 = none)
  task automatic attempt(int n, int wrongAt);
    for (int i = 0; i < n; i++)
      sendSym((i == wrongAt) ? ~nib(i % NSYM) : nib(i % NSYM));
    endAttempt();
  endtask

  task automatic alarm();
    alarmSeen = 1; @(negedge clk); alarmSeen = 0;
  endtask

  task automatic tReset();
    doReset();
    check("R1 enable", reconfigEnable, 0);
    check("R1 lockout", lockout, 0);
    cfgValid = 1; cfgData = 8'h5A;
    check("R1 cfgLoad", cfgLoad, 0);
    check("R1 cfgWord", cfgWord, 0);
    cfgValid = 0;
  endtask

  task automatic tUnlock();
    doReset();
    for (int i = 0; i < NSYM; i++) sendSym(nib(i));
    check("R2 no enable before end", reconfigEnable, 0);
    endAttempt();
    check("R2 enable after end", reconfigEnable, 1);
    cfgValid = 1; cfgData = 8'hC3; #1;
    check("R5 cfgLoad open", cfgLoad, 1);
    check("R5 cfgWord open", cfgWord, 8'hC3);
    cfgValid = 0; #1;
    check("R5 cfgLoad follows", cfgLoad, 0);
    // key traffic while open: no effect, no failures
    for (int k = 0; k < THRESH + 3; k++) attempt(3, 0);
    check("R10 enable kept", reconfigEnable, 1);
    check("R10 no failures counted", lockout, 0);
    repeat (5) @(negedge clk);
    check("R2 enable held", reconfigEnable, 1);
  endtask

  task automatic tWrong();
    doReset();
    attempt(NSYM, 0);
    check("R3 wrong first symbol", reconfigEnable, 0);
    attempt(NSYM, NSYM - 1);
    check("R3 wrong last symbol", reconfigEnable, 0);
    cfgValid = 1; cfgData = 8'hFF; #1;
    check("R5 cfgLoad blocked", cfgLoad, 0);
    check("R5 cfgWord blocked", cfgWord, 0);
    cfgValid = 0;
    attempt(NSYM - 1, -1);
    check("R4 short attempt", reconfigEnable, 0);
    attempt(NSYM + 1, -1);
    check("R4 long attempt", reconfigEnable, 0);
    attempt(NSYM, -1);
    check("R3 retry after failures unlocks", reconfigEnable, 1);
  endtask

  task automatic tLockKeys();
    doReset();
    for (int k = 0; k < THRESH; k++) attempt(NSYM, 2);
    check("R7 no lock at threshold", lockout, 0);
    attempt(NSYM, 5);
    check("R7 lock past threshold", lockout, 1);
    attempt(NSYM, -1);
    check("R7 correct key refused", reconfigEnable, 0);
    repeat (20) @(negedge clk);
    check("R8 lock persists", lockout, 1);
    doReset();
    check("R8 reset clears lock", lockout, 0);
  endtask

  task automatic tLockAlarm();
    doReset();
    attempt(NSYM, -1);
    for (int k = 0; k < THRESH; k++) alarm();
    check("R6 no lock at threshold", lockout, 0);
    check("R6 still enabled", reconfigEnable, 1);
    alarm();
    check("R6 alarm lock", lockout, 1);
    check("R7 enable dropped", reconfigEnable, 0);
    cfgValid = 1; #1;
    check("R5 cfg blocked in lockout", cfgLoad, 0);
    cfgValid = 0;
  endtask

  task automatic tMixed();
    doReset();
    for (int k = 0; k < 3; k++) attempt(NSYM, k);
    attempt(NSYM, -1);
    check("R9 unlocked after fails", reconfigEnable, 1);
    for (int k = 0; k < THRESH - 3; k++) alarm();
    check("R9 no lock at threshold", lockout, 0);
    alarm();
    check("R9 combined count locks", lockout, 1);
  endtask

  initial begin
    fork
      begin
        tReset(); tUnlock(); tWrong(); tLockKeys(); tLockAlarm(); tMixed();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule